// File: doc/BRIEF.md
# Command Packet Receive FIFO

This block collects a short command packet that a host sends byte by byte through its data port, and hands the bytes one at a time to a local microcontroller. A routing bit decides whether host data-port writes go into the 12-entry byte queue at all. The microcontroller drains the queue through one read strobe, and sees the oldest byte on a data output.

The packet length is not fixed at 12. Each time the data-request bit rises, the low nibble of a byte-count value is captured as the completion threshold. Once that many bytes have been taken in, the block raises a packet-complete flag and its active-low twin, the transfer-end flag, and refuses further host writes until the microcontroller has emptied the queue.

Three interrupt sources share one active-low request line:
- the queue holding data,
- transfer end,
- an external sector-ready input.

Each source has its own enable bit. Detection of the packet command opcode from the host can switch the transfer-end enable on by itself. Any of the auxiliary resets clears the sector-ready enable.

Top module: `cmd_pkt_fifo`

## Requirements
- R1: The queue holds up to 12 bytes in arrival order. `cpu_rdata` shows the oldest byte, and a `cpu_rd` strobe removes it at the clock edge. `fne_n` is low whenever at least one byte is stored.
- R2: While the queue is empty, `cpu_rdata` reads 8'hFF, and a `cpu_rd` strobe changes no state.
- R3: A `host_wr` strobe stores `host_wdata` only when `pkt_sel` is high. With `pkt_sel` low the write is lost.
- R4: On the first clock with `drq` high after a clock with `drq` low, `bcnt[3:0]` is captured as the threshold. A captured value of 0 or above 12 means 12. After reset, until the first capture, the threshold is 12.
- R5: `pkt_done` is high and `tend_n` is low exactly when the number of bytes accepted since the queue was last empty is at or above the threshold.
- R6: While `pkt_done` is high, host writes are dropped whatever `pkt_sel` is.
- R7: A read that empties the queue clears the accepted-byte count, so `pkt_done` falls and new writes are taken again.
- R8: An `icr_wr` strobe loads the three enables from `icr_wdata`: bit 7 is the queue-not-empty enable, bit 6 is the transfer-end enable, and bit 5 is the sector-ready enable. `ien_q[2:0]` shows them in that order, with bit 7 at `ien_q[2]`.
- R9: `int_n` is low exactly when an enabled source is active. The sources are: `fne_n` low with `ien_q[2]`, `tend_n` low with `ien_q[1]`, and `sr_n` low with `ien_q[0]`.
- R10: A `host_cmd_wr` carrying 8'hA0 while `hien` and `drv_sel` are both high sets `ien_q[1]` at that edge, even over a simultaneous register write. Any other opcode, or `hien` or `drv_sel` low, leaves `ien_q[1]` alone.
- R11: `ien_q[0]` is cleared by `rst_n` and by a pulse on `host_rst`, `fw_rst` or `dec_rst`. Such a clear wins over a simultaneous `icr_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr | input | 1 | Host data-port write strobe |
| host_wdata | input | 8 | Host data-port byte |
| pkt_sel | input | 1 | Routes host data-port writes into the queue |
| drq | input | 1 | Data-request bit; its rise captures the threshold |
| bcnt | input | 8 | Byte-count value; low nibble is the threshold |
| cpu_rd | input | 1 | Local read strobe of the queue register |
| cpu_rdata | output | 8 | Oldest byte, or FFh when empty |
| icr_wr | input | 1 | Interrupt control write strobe |
| icr_wdata | input | 8 | Interrupt control write data (bits 7:5 used) |
| host_cmd_wr | input | 1 | Host command register write strobe |
| host_cmd | input | 8 | Host command opcode |
| hien | input | 1 | Host interrupt enable bit |
| drv_sel | input | 1 | Drive is selected |
| host_rst | input | 1 | Host reset pulse |
| fw_rst | input | 1 | Firmware reset pulse |
| dec_rst | input | 1 | Decoder reset pulse |
| sr_n | input | 1 | Sector ready, active low |
| fne_n | output | 1 | Queue not empty, active low |
| tend_n | output | 1 | Transfer end, active low |
| pkt_done | output | 1 | Packet complete |
| ien_q | output | 3 | Interrupt enables {not-empty, transfer-end, sector-ready} |
| int_n | output | 1 | Shared interrupt request, active low |

## Verification
The bench sweeps all 16 nibble values. For each one it writes 14 bytes, one at a time, and checks where completion first appears and that bytes after it are lost. A design that mapped 0 or 13–15 wrongly would stop at the wrong byte or overfill. One that kept counting after completion would drop the wrong bytes.

Draining is checked in order, followed by an extra read of the empty queue. A design that cleared the count on any read instead of on the emptying read, or that moved its pointers on an empty read, fails there.

All eight enable combinations are crossed with active and idle sources. The A0h auto-set and the auxiliary clears are each tested against their blocking conditions and against a simultaneous register write, which catches swapped enable bits and a wrong priority.

// File: rtl/cpf_pkg.sv
package cpf_pkg;
  typedef logic [7:0] byte_t;
  localparam byte_t EMPTY_READ = 8'hFF;
  localparam byte_t PKT_OPCODE = 8'hA0;
  localparam int    ICR_LSB    = 5;
  typedef struct packed {
    logic fne;
    logic tend;
    logic sr;
  } ien_t;
endpackage

// File: rtl/cpf_store.sv
module cpf_store
  import cpf_pkg::*;
#(
  parameter int DEPTH = 12,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  byte_t         wdata,
  output byte_t         head,
  output logic [CW-1:0] occ,
  output logic          empty,
  output logic          full
);
  byte_t         mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] occ_q, occ_d;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_d  = push ? bump(wp_q) : wp_q;
    rp_d  = pop  ? bump(rp_q) : rp_q;
    occ_d = occ_q;
    if (push && !pop)      occ_d = occ_q + 1'b1;
    else if (pop && !push) occ_d = occ_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      occ_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      occ_q <= occ_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= wdata;
  end

  assign empty = (occ_q == '0);
  assign full  = (occ_q == CW'(DEPTH));
  assign occ   = occ_q;
  assign head  = empty ? EMPTY_READ : mem[rp_q];
endmodule

// File: rtl/cpf_thresh.sv
module cpf_thresh #(
  parameter int DEPTH = 12,
  parameter int THW   = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           drq,
  input  logic [THW-1:0] cnt_field,
  input  logic           push,
  input  logic           drain,
  output logic           done
);
  logic          drq_q;
  logic          cap;
  logic [CW-1:0] field_eff;
  logic [CW-1:0] thr_q, thr_d;
  logic [CW-1:0] wc_q, wc_d;

  assign cap = drq && !drq_q;

  always_comb begin
    if (cnt_field == '0 || 32'(cnt_field) > DEPTH) field_eff = CW'(DEPTH);
    else                                           field_eff = CW'(cnt_field);
    thr_d = cap ? field_eff : thr_q;
    wc_d  = wc_q;
    if (drain)     wc_d = '0;
    else if (push) wc_d = wc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drq_q <= 1'b0;
      thr_q <= CW'(DEPTH);
      wc_q  <= '0;
    end else begin
      drq_q <= drq;
      thr_q <= thr_d;
      wc_q  <= wc_d;
    end
  end

  assign done = (wc_q >= thr_q);
endmodule

// File: rtl/cpf_irq.sv
module cpf_irq
  import cpf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       icr_wr,
  input  logic [2:0] icr_bits,
  input  logic       cmd_hit,
  input  logic       aux_clr,
  input  logic       fne_act,
  input  logic       tend_act,
  input  logic       sr_act,
  output ien_t       ien_q,
  output logic       int_n
);
  ien_t ien_d;

  always_comb begin
    ien_d = ien_q;
    if (icr_wr)  ien_d = ien_t'(icr_bits);
    if (cmd_hit) ien_d.tend = 1'b1;
    if (aux_clr) ien_d.sr   = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ien_q <= '0;
    else        ien_q <= ien_d;
  end

  assign int_n = !((ien_q.fne && fne_act) || (ien_q.tend && tend_act) ||
                   (ien_q.sr && sr_act));
endmodule

// File: rtl/cmd_pkt_fifo.sv
module cmd_pkt_fifo
  import cpf_pkg::*;
#(
  parameter int DEPTH = 12,
  parameter int THW   = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic [7:0] host_wdata,
  input  logic       pkt_sel,
  input  logic       drq,
  input  logic [7:0] bcnt,
  input  logic       cpu_rd,
  output logic [7:0] cpu_rdata,
  input  logic       icr_wr,
  input  logic [7:0] icr_wdata,
  input  logic       host_cmd_wr,
  input  logic [7:0] host_cmd,
  input  logic       hien,
  input  logic       drv_sel,
  input  logic       host_rst,
  input  logic       fw_rst,
  input  logic       dec_rst,
  input  logic       sr_n,
  output logic       fne_n,
  output logic       tend_n,
  output logic       pkt_done,
  output logic [2:0] ien_q,
  output logic       int_n
);
  logic [1:0]    rs_q;
  logic          rst_sync_n;
  logic          push, pop, drain, empty, full, done;
  logic [CW-1:0] occ;
  ien_t          ien;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  assign push  = host_wr && pkt_sel && !done && !full;
  assign pop   = cpu_rd && !empty;
  assign drain = pop && !push && (occ == CW'(1));

  cpf_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_sync_n), .push(push), .pop(pop),
    .wdata(host_wdata), .head(cpu_rdata), .occ(occ),
    .empty(empty), .full(full)
  );

  cpf_thresh #(.DEPTH(DEPTH), .THW(THW)) u_thresh (
    .clk(clk), .rst_n(rst_sync_n), .drq(drq), .cnt_field(bcnt[THW-1:0]),
    .push(push), .drain(drain), .done(done)
  );

  cpf_irq u_irq (
    .clk(clk), .rst_n(rst_sync_n), .icr_wr(icr_wr),
    .icr_bits(icr_wdata[ICR_LSB+2:ICR_LSB]),
    .cmd_hit(host_cmd_wr && host_cmd == PKT_OPCODE && hien && drv_sel),
    .aux_clr(host_rst || fw_rst || dec_rst),
    .fne_act(!empty), .tend_act(done), .sr_act(!sr_n),
    .ien_q(ien), .int_n(int_n)
  );

  assign fne_n    = empty;
  assign tend_n   = !done;
  assign pkt_done = done;
  assign ien_q    = ien;
endmodule

// File: rtl/cpf_chk.sv
module cpf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_wr,
  input logic       pkt_sel,
  input logic       cpu_rd,
  input logic       drq,
  input logic [7:0] cpu_rdata,
  input logic       fne_n,
  input logic       pkt_done,
  input logic       host_cmd_wr,
  input logic [7:0] host_cmd,
  input logic       hien,
  input logic       drv_sel,
  input logic       host_rst,
  input logic       fw_rst,
  input logic       dec_rst,
  input logic       sr_n,
  input logic [2:0] ien_q,
  input logic       int_n
);
  AST_EMPTY_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
    fne_n |-> cpu_rdata == 8'hFF); // R2
  AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (fne_n && cpu_rd && !host_wr) |=> fne_n); // R2
  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && pkt_sel && !pkt_done) |=> !fne_n); // R3
  AST_UNSEL_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (fne_n && !pkt_sel && !cpu_rd) |=> fne_n); // R3
  AST_DONE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && !cpu_rd && !drq) |=> pkt_done); // R6
  AST_SR_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!sr_n && ien_q[0]) |-> !int_n); // R9
  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == 3'b000) |-> int_n); // R9
  AST_OPCODE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_cmd_wr && host_cmd == 8'hA0 && hien && drv_sel) |=> ien_q[1]); // R10
  AST_AUX_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rst || fw_rst || dec_rst) |=> !ien_q[0]); // R11
endmodule

bind cmd_pkt_fifo cpf_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .host_wr(host_wr), .pkt_sel(pkt_sel),
  .cpu_rd(cpu_rd), .drq(drq), .cpu_rdata(cpu_rdata), .fne_n(fne_n),
  .pkt_done(pkt_done), .host_cmd_wr(host_cmd_wr), .host_cmd(host_cmd),
  .hien(hien), .drv_sel(drv_sel), .host_rst(host_rst), .fw_rst(fw_rst),
  .dec_rst(dec_rst), .sr_n(sr_n), .ien_q(ien_q), .int_n(int_n)
);

// File: tb/tb_cmd_pkt_fifo.sv
module tb_cmd_pkt_fifo;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 0, pkt_sel = 0, drq = 0, cpu_rd = 0, icr_wr = 0;
  logic host_cmd_wr = 0, hien = 0, drv_sel = 0;
  logic host_rst = 0, fw_rst = 0, dec_rst = 0, sr_n = 1;
  logic [7:0] host_wdata = 0, bcnt = 0, icr_wdata = 0, host_cmd = 0;
  logic [7:0] cpu_rdata;
  logic fne_n, tend_n, pkt_done, int_n;
  logic [2:0] ien_q;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] mq [12];
  int m_occ = 0, m_wc = 0, m_thr = 12, m_head = 0;

  always #2 clk = ~clk;

  cmd_pkt_fifo dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit m_done();
    return m_wc >= m_thr;
  endfunction

  task automatic check_state(input string req);
    chk({req, " fne_n"}, fne_n, (m_occ == 0));
    chk({req, " pkt_done"}, pkt_done, m_done());
    chk({req, " tend_n"}, tend_n, !m_done());
    chk({req, " rdata"}, cpu_rdata, (m_occ == 0) ? 8'hFF : mq[m_head]);
  endtask

  task automatic wr_byte(input logic [7:0] d, input logic sel);
    bit acc;
    @(negedge clk);
    acc = sel && !m_done() && m_occ < 12;
    host_wr = 1; host_wdata = d; pkt_sel = sel;
    @(negedge clk);
    host_wr = 0;
    if (acc) begin
      mq[(m_head + m_occ) % 12] = d;
      m_occ++; m_wc++;
    end
  endtask

  task automatic rd_byte();
    @(negedge clk);
    cpu_rd = 1;
    @(negedge clk);
    cpu_rd = 0;
    if (m_occ > 0) begin
      m_head = (m_head + 1) % 12;
      m_occ--;
      if (m_occ == 0) m_wc = 0;
    end
  endtask

  task automatic set_thr(input int t);
    @(negedge clk);
    drq = 0; bcnt = 8'(t) | 8'hA0;
    @(negedge clk);
    drq = 1;
    @(negedge clk);
    drq = 0;
    m_thr = (t == 0 || t > 12) ? 12 : t;
  endtask

  task automatic icr(input logic [2:0] e);
    @(negedge clk);
    icr_wr = 1; icr_wdata = {e, 5'b10101};
    @(negedge clk);
    icr_wr = 0;
  endtask

  task automatic drain(input string req);
    while (m_occ > 0) begin
      check_state(req);
      rd_byte();
    end
    check_state(req);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // reset state
    check_state("R1 reset");
    chk("R8 reset ien", ien_q, 0);
    chk("R9 reset int_n", int_n, 1);

    // R3: deselected writes are lost
    wr_byte(8'h55, 0);
    check_state("R3 unselected");

    // R4: default threshold of 12 before any capture
    for (int i = 0; i < 13; i++) begin
      wr_byte(8'(8'h30 + i), 1);
      check_state("R4 default");
    end
    drain("R1 order");

    // R2: read while empty
    rd_byte();
    check_state("R2 empty read");

    // R4 R5 R6 R7: every nibble value
    for (int t = 0; t < 16; t++) begin
      set_thr(t);
      for (int i = 0; i < 14; i++) begin
        wr_byte(8'(t * 16 + i), 1);
        check_state("R5 R6 sweep");
      end
      drain("R7 drain");
      rd_byte();
      check_state("R2 after drain");
    end

    // R8 R9: enables crossed with sources
    for (int st = 0; st < 2; st++) begin
      if (st == 1) begin
        set_thr(1);
        wr_byte(8'h77, 1);
      end
      for (int e = 0; e < 8; e++) begin
        for (int s = 0; s < 2; s++) begin
          icr(3'(e));
          sr_n = s[0];
          @(negedge clk);
          chk("R8 ien", ien_q, e);
          chk("R9 int_n", int_n,
              !((e[2] && m_occ > 0) || (e[1] && m_done()) || (e[0] && !s[0])));
        end
      end
      sr_n = 1;
    end
    drain("R7 irq drain");

    // R10: opcode auto-set and its blocking cases
    for (int k = 0; k < 5; k++) begin
      icr(3'b000);
      @(negedge clk);
      host_cmd_wr = 1;
      host_cmd = (k == 1) ? 8'hA1 : 8'hA0;
      hien = (k != 2);
      drv_sel = (k != 3);
      icr_wr = (k == 4); icr_wdata = 8'h00;
      @(negedge clk);
      host_cmd_wr = 0; icr_wr = 0;
      chk("R10 auto-set", ien_q[1], (k == 0 || k == 4));
    end

    // R11: auxiliary resets clear sector-ready enable
    for (int k = 0; k < 4; k++) begin
      icr(3'b111);
      @(negedge clk);
      host_rst = (k == 0); fw_rst = (k == 1); dec_rst = (k >= 2);
      icr_wr = (k == 3); icr_wdata = 8'hE0;
      @(negedge clk);
      host_rst = 0; fw_rst = 0; dec_rst = 0; icr_wr = 0;
      chk("R11 aux clear", ien_q, 3'b110);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule